// File: doc/BRIEF.md
# Port-to-Port Mailbox Interrupt Logic

This block sits beside a two-port memory and lets the two sides signal each other. The two highest addresses of the shared address space are mailboxes. The all-ones address belongs to the right port and the address one below it belongs to the left port. When one port writes the mailbox owned by the other port, the owner's active-low interrupt output goes low. The owner reads its own mailbox to take the message, and that read releases the interrupt.

The block holds only the two mailbox words. Reads of any other address return zero, because the rest of the memory lives outside this block. Each port has an enable, an address, a read strobe, a write strobe, write data and registered read data. All state is synchronous to one clock, and an active-high synchronous reset clears it.

Top module: `mbx_irq_top`

## Requirements
- R1: While reset is high and on the cycle after it, both interrupt outputs are high, both read-data outputs are zero and both mailbox words hold zero.
- R2: The right port's mailbox is at address 2^ADDR_W-1 and the left port's mailbox is at 2^ADDR_W-2. Both are derived from the address-width parameter.
- R3: An enabled left-port write to the right mailbox drives r_irq_n low from the next clock edge.
- R4: An enabled right-port write to the left mailbox drives l_irq_n low from the next clock edge.
- R5: An enabled read by a port of its own mailbox drives that port's interrupt high from the next clock edge. A read of the other port's mailbox leaves both interrupts unchanged.
- R6: A port writing its own mailbox, or writing any address other than the peer's mailbox, never lowers an interrupt output.
- R7: If a set and a clear of the same interrupt happen in one cycle, the interrupt is low after that edge.
- R8: A read or write strobe with the port's enable low changes no interrupt, no mailbox word and no read data.
- R9: An enabled read returns, on the next cycle, the mailbox word as it stood before that edge: the word for either mailbox address, and zero for any other address.
- R10: When both ports write the same mailbox in one cycle, the word keeps the data from the port that does not own it.
- R11: Read data holds its value in every cycle without an enabled read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_en | input | 1 | Left port enable |
| l_addr | input | ADDR_W | Left port address |
| l_rd | input | 1 | Left port read strobe |
| l_wr | input | 1 | Left port write strobe |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port read data, registered |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_en | input | 1 | Right port enable |
| r_addr | input | ADDR_W | Right port address |
| r_rd | input | 1 | Right port read strobe |
| r_wr | input | 1 | Right port write strobe |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port read data, registered |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
A flag that is set or cleared wrongly shows at its interrupt pin one edge after the offending access, so the reference model catches it on the next compare. A wrong mailbox word stays hidden until some port reads that mailbox. The bench therefore reads each mailbox soon after writing it, and also after every same-cycle write collision, so that a bad word appears on the read data within two cycles. Randomised traffic that favours the two top addresses exercises the set-wins and write-priority cases that directed stimulus might miss.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Width limit for the address helpers below.
    localparam int unsigned MAX_AW = 32;

    // Port side. The index order (left = 0, right = 1) is used throughout.
    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

    // Decoded access of one port for one cycle.
    typedef struct packed {
        logic rd_en;    // enabled read of any address
        logic rd_own;   // enabled read of own mailbox
        logic rd_peer;  // enabled read of the other side's mailbox
        logic wr_own;   // enabled write to own mailbox
        logic wr_peer;  // enabled write to the other side's mailbox
    } port_hit_t;

    function automatic side_e other_side(side_e s);
        return (s == SIDE_L) ? SIDE_R : SIDE_L;
    endfunction

    // Mailbox location owned by side s for an address width aw (2..31).
    // The right side owns all ones, the left side owns the word below it.
    function automatic logic [MAX_AW-1:0] mbx_loc(side_e s, int unsigned aw);
        logic [MAX_AW-1:0] top;
        top = {MAX_AW{1'b1}} >> (MAX_AW - aw);
        return (s == SIDE_L) ? (top - 1'b1) : top;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter side_e       SIDE   = SIDE_L
) (
    input  logic              en,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output port_hit_t         hit
);
    localparam logic [MAX_AW-1:0] OWN_FULL  = mbx_loc(SIDE, ADDR_W);
    localparam logic [MAX_AW-1:0] PEER_FULL = mbx_loc(other_side(SIDE), ADDR_W);
    localparam logic [ADDR_W-1:0] OWN_LOC   = OWN_FULL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] PEER_LOC  = PEER_FULL[ADDR_W-1:0];

    logic at_own;
    logic at_peer;

    always_comb begin
        at_own       = (addr == OWN_LOC);
        at_peer      = (addr == PEER_LOC);
        hit.rd_en    = en && rd;
        hit.rd_own   = en && rd && at_own;
        hit.rd_peer  = en && rd && at_peer;
        hit.wr_own   = en && wr && at_own;
        hit.wr_peer  = en && wr && at_peer;
    end

endmodule

// File: rtl/mbx_word.sv
module mbx_word #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_from_peer,
    input  logic [DATA_W-1:0] peer_data,
    input  logic              wr_from_own,
    input  logic [DATA_W-1:0] own_data,
    output logic [DATA_W-1:0] q
);
    // The sender's message wins a same-cycle collision with the owner.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_from_peer) begin
            q <= peer_data;
        end else if (wr_from_own) begin
            q <= own_data;
        end
    end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    logic pending;

    // A set beats a clear in the same cycle so no message is lost.
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (set) begin
            pending <= 1'b1;
        end else if (clr) begin
            pending <= 1'b0;
        end
    end

    assign irq_n = ~pending;

endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  port_hit_t         hit,
    input  logic [DATA_W-1:0] own_word,
    input  logic [DATA_W-1:0] peer_word,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] sel_word;

    always_comb begin
        if (hit.rd_own) begin
            sel_word = own_word;
        end else if (hit.rd_peer) begin
            sel_word = peer_word;
        end else begin
            sel_word = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (hit.rd_en) begin
            rdata <= sel_word;
        end
    end

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_rd,
    input  logic              l_wr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_rd,
    input  logic              r_wr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);
    localparam int unsigned NSIDE = 2;

    logic              p_en    [NSIDE];
    logic              p_rd    [NSIDE];
    logic              p_wr    [NSIDE];
    logic [ADDR_W-1:0] p_addr  [NSIDE];
    logic [DATA_W-1:0] p_wdata [NSIDE];
    logic [DATA_W-1:0] p_rdata [NSIDE];
    logic              p_irq_n [NSIDE];
    port_hit_t         p_hit   [NSIDE];
    logic [DATA_W-1:0] box     [NSIDE];

    always_comb begin
        p_en[SIDE_L]    = l_en;
        p_rd[SIDE_L]    = l_rd;
        p_wr[SIDE_L]    = l_wr;
        p_addr[SIDE_L]  = l_addr;
        p_wdata[SIDE_L] = l_wdata;
        p_en[SIDE_R]    = r_en;
        p_rd[SIDE_R]    = r_rd;
        p_wr[SIDE_R]    = r_wr;
        p_addr[SIDE_R]  = r_addr;
        p_wdata[SIDE_R] = r_wdata;
    end

    assign l_rdata = p_rdata[SIDE_L];
    assign r_rdata = p_rdata[SIDE_R];
    assign l_irq_n = p_irq_n[SIDE_L];
    assign r_irq_n = p_irq_n[SIDE_R];

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam side_e ME   = side_e'(s);
        localparam int    PEER = 1 - s;

        mbx_port_decode #(
            .ADDR_W (ADDR_W),
            .SIDE   (ME)
        ) u_dec (
            .en   (p_en[s]),
            .rd   (p_rd[s]),
            .wr   (p_wr[s]),
            .addr (p_addr[s]),
            .hit  (p_hit[s])
        );

        // Word owned by side s: written by the peer (priority) or by s.
        mbx_word #(
            .DATA_W (DATA_W)
        ) u_word (
            .clk          (clk),
            .rst          (rst),
            .wr_from_peer (p_hit[PEER].wr_peer),
            .peer_data    (p_wdata[PEER]),
            .wr_from_own  (p_hit[s].wr_own),
            .own_data     (p_wdata[s]),
            .q            (box[s])
        );

        // Interrupt of side s: raised by a peer write, dropped by own read.
        mbx_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set   (p_hit[PEER].wr_peer),
            .clr   (p_hit[s].rd_own),
            .irq_n (p_irq_n[s])
        );

        mbx_rd_port #(
            .DATA_W (DATA_W)
        ) u_rd (
            .clk       (clk),
            .rst       (rst),
            .hit       (p_hit[s]),
            .own_word  (box[s]),
            .peer_word (box[PEER]),
            .rdata     (p_rdata[s])
        );
    end

endmodule

// File: rtl/mbx_irq_checker.sv
module mbx_irq_checker #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              l_en,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_rd,
    input logic              l_wr,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_irq_n,
    input logic              r_en,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_rd,
    input logic              r_wr,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] R_BOX = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] L_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic l_to_r, r_to_l, r_take, l_take;
    assign l_to_r = l_en && l_wr && (l_addr == R_BOX);
    assign r_to_l = r_en && r_wr && (r_addr == L_BOX);
    assign r_take = r_en && r_rd && (r_addr == R_BOX);
    assign l_take = l_en && l_rd && (l_addr == L_BOX);

    assert_right_raise_R3: assert property (@(posedge clk) disable iff (rst)
        l_to_r |=> !r_irq_n);

    assert_left_raise_R4: assert property (@(posedge clk) disable iff (rst)
        r_to_l |=> !l_irq_n);

    assert_right_release_R5: assert property (@(posedge clk) disable iff (rst)
        (r_take && !l_to_r) |=> r_irq_n);

    assert_left_release_R5: assert property (@(posedge clk) disable iff (rst)
        (l_take && !r_to_l) |=> l_irq_n);

    assert_right_only_peer_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(r_irq_n) |-> $past(l_to_r));

    assert_left_only_peer_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(l_irq_n) |-> $past(r_to_l));

    assert_left_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !(l_en && l_rd) |=> $stable(l_rdata));

    assert_right_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !(r_en && r_rd) |=> $stable(r_rdata));

endmodule

bind mbx_irq_top mbx_irq_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .l_en    (l_en),
    .l_addr  (l_addr),
    .l_rd    (l_rd),
    .l_wr    (l_wr),
    .l_rdata (l_rdata),
    .l_irq_n (l_irq_n),
    .r_en    (r_en),
    .r_addr  (r_addr),
    .r_rd    (r_rd),
    .r_wr    (r_wr),
    .r_rdata (r_rdata),
    .r_irq_n (r_irq_n)
);

// File: tb/mbx_irq_top_tb.sv
`timescale 1ns/1ps
module mbx_irq_top_tb;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] RBOX = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] LBOX = RBOX - 1'b1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_en = 0, l_rd = 0, l_wr = 0, r_en = 0, r_rd = 0, r_wr = 0;
    logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
    logic [DATA_W-1:0] l_wdata = '0, r_wdata = '0;
    logic [DATA_W-1:0] l_rdata, r_rdata;
    logic l_irq_n, r_irq_n;

    always #4 clk = ~clk;

    mbx_irq_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst),
        .l_en(l_en), .l_addr(l_addr), .l_rd(l_rd), .l_wr(l_wr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_en(r_en), .r_addr(r_addr), .r_rd(r_rd), .r_wr(r_wr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    int total = 0;
    int bad = 0;
    bit cmp_on = 0;
    bit done = 0;

    // Behavioural reference state.
    int m_lflag = 0, m_rflag = 0;
    int m_lbox = 0, m_rbox = 0;
    int m_lrd = 0, m_rrd = 0;

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int nl, nr, nlb, nrb, nlr, nrr;
        bit lw_r, rw_l, lw_own, rw_own, lr_own, rr_own;
        if (rst) begin
            m_lflag = 0; m_rflag = 0; m_lbox = 0; m_rbox = 0; m_lrd = 0; m_rrd = 0;
        end else begin
            lw_r   = l_en && l_wr && l_addr == RBOX;
            lw_own = l_en && l_wr && l_addr == LBOX;
            rw_l   = r_en && r_wr && r_addr == LBOX;
            rw_own = r_en && r_wr && r_addr == RBOX;
            lr_own = l_en && l_rd && l_addr == LBOX;
            rr_own = r_en && r_rd && r_addr == RBOX;
            nlr = m_lrd; nrr = m_rrd;
            if (l_en && l_rd)
                nlr = (l_addr == RBOX) ? m_rbox : (l_addr == LBOX) ? m_lbox : 0;
            if (r_en && r_rd)
                nrr = (r_addr == RBOX) ? m_rbox : (r_addr == LBOX) ? m_lbox : 0;
            nrb = lw_r ? int'(l_wdata) : rw_own ? int'(r_wdata) : m_rbox;
            nlb = rw_l ? int'(r_wdata) : lw_own ? int'(l_wdata) : m_lbox;
            nr = lw_r ? 1 : rr_own ? 0 : m_rflag;
            nl = rw_l ? 1 : lr_own ? 0 : m_lflag;
            m_lflag = nl; m_rflag = nr; m_lbox = nlb; m_rbox = nrb;
            m_lrd = nlr; m_rrd = nrr;
        end
    end

    // Model compare on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R3_R4_R5 l_irq_n model", int'(l_irq_n), m_lflag ? 0 : 1);
            check("R3_R4_R5 r_irq_n model", int'(r_irq_n), m_rflag ? 0 : 1);
            check("R9 l_rdata model", int'(l_rdata), m_lrd);
            check("R9 r_rdata model", int'(r_rdata), m_rrd);
        end
    end

    task automatic drive(input bit le, lr, lw, input int la, ld,
                         input bit re, rr, rw, input int ra, rd);
        l_en = le; l_rd = lr; l_wr = lw; l_addr = ADDR_W'(la); l_wdata = DATA_W'(ld);
        r_en = re; r_rd = rr; r_wr = rw; r_addr = ADDR_W'(ra); r_wdata = DATA_W'(rd);
        @(negedge clk);
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    localparam int RB = (1 << ADDR_W) - 1;
    localparam int LB = (1 << ADDR_W) - 2;

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 l_irq_n in reset", int'(l_irq_n), 1);
        check("R1 r_irq_n in reset", int'(r_irq_n), 1);
        rst = 1'b0;
        @(negedge clk);
        cmp_on = 1;
        check("R1 l_rdata after reset", int'(l_rdata), 0);
        check("R1 r_rdata after reset", int'(r_rdata), 0);

        // R6: own write and write elsewhere raise nothing.
        drive(1, 0, 1, LB, 'h11, 1, 0, 1, 5, 'h22);
        check("R6 l_irq_n own write", int'(l_irq_n), 1);
        check("R6 r_irq_n other addr", int'(r_irq_n), 1);

        // R3 / R2: left writes the all-ones mailbox.
        drive(1, 0, 1, RB, 'hA5, 0, 0, 0, 0, 0);
        check("R3 r_irq_n low", int'(r_irq_n), 0);
        check("R3 l_irq_n unaffected", int'(l_irq_n), 1);

        // R5: peer-mailbox read does not clear.
        drive(0, 0, 0, 0, 0, 1, 1, 0, LB, 0);
        check("R5 peer read keeps r_irq_n", int'(r_irq_n), 0);
        check("R9 r reads left box", int'(r_rdata), 'h11);

        // R8: disabled read of own mailbox.
        drive(0, 0, 0, 0, 0, 0, 1, 0, RB, 0);
        check("R8 disabled read keeps irq", int'(r_irq_n), 0);
        check("R8 disabled read keeps rdata", int'(r_rdata), 'h11);

        // R5 / R9: owner read clears.
        drive(0, 0, 0, 0, 0, 1, 1, 0, RB, 0);
        check("R5 own read clears r_irq_n", int'(r_irq_n), 1);
        check("R9 r reads own box", int'(r_rdata), 'hA5);

        // R11: no read, data holds.
        idle();
        check("R11 r_rdata holds", int'(r_rdata), 'hA5);

        // R8: disabled write to peer mailbox.
        drive(0, 0, 0, 0, 0, 0, 0, 1, LB, 'hEE);
        check("R8 disabled write no irq", int'(l_irq_n), 1);
        drive(1, 1, 0, LB, 0, 0, 0, 0, 0, 0);
        check("R8 disabled write no data", int'(l_rdata), 'h11);

        // R4: right writes left mailbox.
        drive(0, 0, 0, 0, 0, 1, 0, 1, LB, 'h3C);
        check("R4 l_irq_n low", int'(l_irq_n), 0);

        // R7 + read-before-write (R9).
        drive(1, 1, 0, LB, 0, 1, 0, 1, LB, 'h5A);
        check("R7 set wins over clear", int'(l_irq_n), 0);
        check("R9 read returns old word", int'(l_rdata), 'h3C);
        drive(1, 1, 0, LB, 0, 0, 0, 0, 0, 0);
        check("R5 left own read clears", int'(l_irq_n), 1);
        check("R9 new word visible", int'(l_rdata), 'h5A);

        // R10: both write the right mailbox.
        drive(1, 0, 1, RB, 'hC3, 1, 0, 1, RB, 'h99);
        drive(0, 0, 0, 0, 0, 1, 1, 0, RB, 0);
        check("R10 sender data kept", int'(r_rdata), 'hC3);
        check("R5 cleared after collision", int'(r_irq_n), 1);

        // R9: non-mailbox read gives zero.
        drive(1, 1, 0, 7, 0, 0, 0, 0, 0, 0);
        check("R9 other address zero", int'(l_rdata), 0);

        // Random traffic biased to the mailbox addresses, model compared.
        for (int i = 0; i < 600; i++) begin
            int la, ra;
            la = ($urandom_range(3) == 0) ? $urandom_range(RB) : LB + $urandom_range(1);
            ra = ($urandom_range(3) == 0) ? $urandom_range(RB) : LB + $urandom_range(1);
            drive($urandom_range(4) != 0, $urandom_range(1), $urandom_range(1), la,
                  $urandom_range(255),
                  $urandom_range(4) != 0, $urandom_range(1), $urandom_range(1), ra,
                  $urandom_range(255));
        end
        idle();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule